// File: doc/BRIEF.md
# Configuration Load Sequencer

This block steps a programmable device through bring-up. After a power-on event or a program request it does three things in order. First it writes zero to every configuration frame by walking a frame address counter. Next it takes a serial configuration stream that begins with a length word. Last it runs a timed start-up that frees the user logic and then reports completion. The init line is open-drain: the block pulls it low while it holds the device in reset and while it clears memory. It senses the wired level separately, so an outside agent holding the line low can stall the block before the load.

A global set/reset output keeps user flip-flops in reset until start-up has counted out its first delay. The done output rises only after the whole sequence has finished. A faulty stream (length too large, stream cut short) or the init line pulled low during the load sends the block to a fault state. The block stays there until a new program request arrives.

Top module: `cfg_sequencer`

## Requirements
- R1: While `rst` is high or `pwr_good` is low, the block sits in reset with `init_drive_low`=1, `gsr`=1, `done`=0 and `clr_we`=0, and it remains there for as long as `pwr_good` stays low.
- R2: Clearing begins on the first clock edge at which `pwr_good` is high and `prog_req` is low while in reset. After that edge `clr_we` is high for exactly NUM_FRAMES consecutive cycles, `clr_addr` goes 0,1,…,NUM_FRAMES-1, and `init_drive_low` is 1 throughout.
- R3: Once clearing ends, `init_drive_low` drops to 0. While `init_sense` reads 0 the block waits and ignores `din_valid`. It enters the load one edge after `init_sense` reads 1.
- R4: During the load, the first 32 accepted bits (`din_valid`=1) form the payload length in bits, MSB first. Each group of 32 payload bits after that is shown on `cfg_word` with a one-cycle `cfg_word_vld`, and the first bit of the group sits in bit 31.
- R5: `gsr` stays 1 from reset through clearing, waiting and loading, and for the first GSR_DLY cycles of start-up.
- R6: Count the edges after the one that accepts the final payload bit. `gsr` first reads 0 after GSR_DLY+1 of them, and `done` first reads 1 after GSR_DLY+DONE_DLY+1 of them. `done` then stays 1 and `gsr` stays 0.
- R7: A length word above 4,294,967,264 sends the block to the fault state. A length word equal to 4,294,967,264 is accepted.
- R8: `din_last` on an accepted bit before the declared length is reached sends the block to the fault state.
- R9: `init_sense` reading 0 at any edge during the load sends the block to the fault state.
- R10: In the fault state `init_drive_low`=1, `gsr`=1 and `done`=0. Further stream bits change none of these.
- R11: `prog_req` high from any state returns the block to reset (as in R1) at the next edge and keeps it there while high. Its release starts a fresh sequence as in R2.
- R12: Bits arriving once the declared length is reached are not taken, and a final group shorter than 32 bits produces no `cfg_word_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | High once all supplies are above threshold |
| prog_req | input | 1 | Program request, restarts the sequence |
| init_sense | input | 1 | Sensed level of the wired init line |
| init_drive_low | output | 1 | Pulls the init line low when 1 |
| din | input | 1 | Serial configuration data bit |
| din_valid | input | 1 | Strobe qualifying `din` |
| din_last | input | 1 | Marks the final bit of the stream |
| clr_addr | output | FRAME_AW | Frame address being cleared |
| clr_we | output | 1 | Write-zero strobe for the addressed frame |
| cfg_word | output | 32 | Assembled configuration word |
| cfg_word_vld | output | 1 | One-cycle strobe for `cfg_word` |
| gsr | output | 1 | Global set/reset to user logic |
| done | output | 1 | Configuration complete |

## Verification
Stream lengths are drawn at random from 0 to 160 bits, with and without idle gaps between strobes. These runs show whether word assembly and completion depend on strobe spacing, and whether lengths that are not multiples of 32 leave a partial word unreported. Directed streams separate the fault causes: a `din_last` that comes too early, a length one above the limit compared with a length exactly at it, and the init line pulled low mid-load. An outside agent stalling the init line is run next to an unstalled start, which shows that bits sent during the stall are dropped. Program requests issued from the operate and fault states, and a power-good drop, show that the sequence restarts from any state.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    localparam int unsigned WORD_W = 32;
    localparam logic [31:0] MAX_STREAM_BITS = 32'd4294967264;

    typedef enum logic [2:0] {
        SEQ_RESET,
        SEQ_CLEAR,
        SEQ_INIT_WAIT,
        SEQ_LOAD,
        SEQ_STARTUP,
        SEQ_OPERATE,
        SEQ_ERROR
    } seq_state_t;

    typedef struct packed {
        logic len_bad;
        logic complete;
        logic early_end;
    } rx_status_t;

    typedef struct packed {
        logic drive_init_low;
        logic gsr;
        logic done;
    } pin_out_t;

    function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] w, input logic b);
        return {w[WORD_W-2:0], b};
    endfunction

    function automatic pin_out_t decode_pins(input seq_state_t s, input logic gsr_rel);
        pin_out_t p;
        p.drive_init_low = (s == SEQ_RESET) || (s == SEQ_CLEAR) || (s == SEQ_ERROR);
        p.done           = (s == SEQ_OPERATE);
        p.gsr            = !((s == SEQ_OPERATE) || ((s == SEQ_STARTUP) && gsr_rel));
        return p;
    endfunction

endpackage

// File: rtl/cfg_frame_clear.sv
module cfg_frame_clear #(
    parameter int unsigned NUM_FRAMES = 16,
    localparam int unsigned FRAME_AW = (NUM_FRAMES > 2) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    output logic [FRAME_AW-1:0] addr,
    output logic                we,
    output logic                wrap
);
    localparam logic [FRAME_AW-1:0] LAST = FRAME_AW'(NUM_FRAMES - 1);

    logic [FRAME_AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            addr_q <= '0;
        end else if (addr_q == LAST) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;
    assign we   = en;
    assign wrap = en && (addr_q == LAST);

    // R2: consecutive frames while clearing continues
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && !wrap) |=> (!en || (addr_q == $past(addr_q) + 1'b1)));

    // R2: a clear run always starts from frame zero
    assert_start_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> (addr_q == '0));

endmodule

// File: rtl/cfg_stream_rx.sv
module cfg_stream_rx
    import cfgseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              din,
    input  logic              din_valid,
    input  logic              din_last,
    output logic [WORD_W-1:0] word,
    output logic              word_vld,
    output rx_status_t        status
);
    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] len_q;
    logic [WORD_W-1:0] pay_cnt_q;
    logic [4:0]        hdr_cnt_q;
    logic              hdr_have_q;
    logic              word_vld_q;

    logic [WORD_W-1:0] sh_nxt;
    logic              len_bad;
    logic              reached;
    logic              accept_hdr;
    logic              accept_pay;
    logic              finishing;

    assign sh_nxt     = shift_in(sh_q, din);
    assign len_bad    = hdr_have_q && (len_q > MAX_STREAM_BITS);
    assign reached    = hdr_have_q && (pay_cnt_q == len_q);
    assign accept_hdr = en && din_valid && !hdr_have_q;
    assign accept_pay = en && din_valid && hdr_have_q && !reached && !len_bad;

    always_comb begin
        if (hdr_have_q) begin
            finishing = (({1'b0, pay_cnt_q} + 33'd1) == {1'b0, len_q});
        end else begin
            finishing = (hdr_cnt_q == 5'd31) && (sh_nxt == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sh_q       <= '0;
            len_q      <= '0;
            pay_cnt_q  <= '0;
            hdr_cnt_q  <= '0;
            hdr_have_q <= 1'b0;
            word_vld_q <= 1'b0;
        end else begin
            word_vld_q <= 1'b0;
            if (accept_hdr) begin
                sh_q      <= sh_nxt;
                hdr_cnt_q <= hdr_cnt_q + 1'b1;
                if (hdr_cnt_q == 5'd31) begin
                    hdr_have_q <= 1'b1;
                    len_q      <= sh_nxt;
                end
            end else if (accept_pay) begin
                sh_q       <= sh_nxt;
                pay_cnt_q  <= pay_cnt_q + 1'b1;
                word_vld_q <= (pay_cnt_q[4:0] == 5'd31);
            end
        end
    end

    assign word             = sh_q;
    assign word_vld         = word_vld_q;
    assign status.len_bad   = len_bad;
    assign status.complete  = reached && !len_bad;
    assign status.early_end = en && din_valid && din_last && !finishing && !reached;

    // R4: a word strobe needs 32 fresh bits, so it never repeats back to back
    assert_word_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        word_vld_q |=> !word_vld_q);

    // R12: the payload counter never passes the declared length
    assert_no_overrun_R12: assert property (@(posedge clk) disable iff (rst)
        (en && hdr_have_q && reached) |=> (!en || (pay_cnt_q == $past(pay_cnt_q))));

endmodule

// File: rtl/cfg_startup_timer.sv
module cfg_startup_timer #(
    parameter int unsigned GSR_DLY  = 4,
    parameter int unsigned DONE_DLY = 3,
    localparam int unsigned TOTAL = GSR_DLY + DONE_DLY,
    localparam int unsigned CW    = $clog2(TOTAL + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic gsr_rel,
    output logic fin
);
    localparam logic [CW-1:0] GSR_C = CW'(GSR_DLY);
    localparam logic [CW-1:0] END_C = CW'(TOTAL - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q != END_C) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign gsr_rel = en && (cnt_q >= GSR_C);
    assign fin     = en && (cnt_q == END_C);

    // R6: completion is reached only after the set/reset release point
    assert_fin_after_rel_R6: assert property (@(posedge clk) disable iff (rst)
        fin |-> gsr_rel);

endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
    import cfgseq_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 16,
    parameter int unsigned GSR_DLY    = 4,
    parameter int unsigned DONE_DLY   = 3,
    localparam int unsigned FRAME_AW  = (NUM_FRAMES > 2) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pwr_good,
    input  logic                prog_req,
    input  logic                init_sense,
    output logic                init_drive_low,
    input  logic                din,
    input  logic                din_valid,
    input  logic                din_last,
    output logic [FRAME_AW-1:0] clr_addr,
    output logic                clr_we,
    output logic [WORD_W-1:0]   cfg_word,
    output logic                cfg_word_vld,
    output logic                gsr,
    output logic                done
);
    seq_state_t st_q, st_nxt;
    rx_status_t rx_st;
    pin_out_t   pins;
    logic       clr_wrap;
    logic       gsr_rel;
    logic       su_fin;

    cfg_frame_clear #(.NUM_FRAMES(NUM_FRAMES)) clear_i (
        .clk  (clk),
        .rst  (rst),
        .en   (st_q == SEQ_CLEAR),
        .addr (clr_addr),
        .we   (clr_we),
        .wrap (clr_wrap)
    );

    cfg_stream_rx rx_i (
        .clk       (clk),
        .rst       (rst),
        .en        (st_q == SEQ_LOAD),
        .din       (din),
        .din_valid (din_valid),
        .din_last  (din_last),
        .word      (cfg_word),
        .word_vld  (cfg_word_vld),
        .status    (rx_st)
    );

    cfg_startup_timer #(.GSR_DLY(GSR_DLY), .DONE_DLY(DONE_DLY)) su_i (
        .clk     (clk),
        .rst     (rst),
        .en      (st_q == SEQ_STARTUP),
        .gsr_rel (gsr_rel),
        .fin     (su_fin)
    );

    always_comb begin
        st_nxt = st_q;
        if (!pwr_good || prog_req) begin
            st_nxt = SEQ_RESET;
        end else begin
            case (st_q)
                SEQ_RESET:     st_nxt = SEQ_CLEAR;
                SEQ_CLEAR:     if (clr_wrap) st_nxt = SEQ_INIT_WAIT;
                SEQ_INIT_WAIT: if (init_sense) st_nxt = SEQ_LOAD;
                SEQ_LOAD: begin
                    if (!init_sense || rx_st.early_end || rx_st.len_bad) begin
                        st_nxt = SEQ_ERROR;
                    end else if (rx_st.complete) begin
                        st_nxt = SEQ_STARTUP;
                    end
                end
                SEQ_STARTUP:   if (su_fin) st_nxt = SEQ_OPERATE;
                SEQ_OPERATE:   st_nxt = SEQ_OPERATE;
                SEQ_ERROR:     st_nxt = SEQ_ERROR;
                default:       st_nxt = SEQ_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SEQ_RESET;
        end else begin
            st_q <= st_nxt;
        end
    end

    assign pins           = decode_pins(st_q, gsr_rel);
    assign init_drive_low = pins.drive_init_low;
    assign gsr            = pins.gsr;
    assign done           = pins.done;

    // R6: completion never coexists with user logic held in reset
    assert_done_no_gsr_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !gsr);

    // R2: init line held low whenever frames are being cleared
    assert_init_low_clear_R2: assert property (@(posedge clk) disable iff (rst)
        clr_we |-> init_drive_low);

    // R5: user logic stays in reset across the whole load
    assert_load_gsr_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEQ_LOAD) |-> gsr);

    // R10: the fault state is left only by program request or power loss
    assert_error_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEQ_ERROR && pwr_good && !prog_req) |=> (st_q == SEQ_ERROR));

    // R11: a program request lands in reset on the next edge
    assert_prog_restart_R11: assert property (@(posedge clk) disable iff (rst)
        prog_req |=> (st_q == SEQ_RESET));

endmodule

// File: tb/cfg_sequencer_tb_top.sv
module cfg_sequencer_tb_top;
    localparam int NF     = 16;
    localparam int GSR_D  = 4;
    localparam int DONE_D = 3;
    localparam int AW     = $clog2(NF);

    logic clk = 1'b0;
    logic rst, pwr_good, prog_req, ext_low;
    logic din, din_valid, din_last;
    logic init_sense, init_drive_low, clr_we, cfg_word_vld, gsr, done;
    logic [AW-1:0] clr_addr;
    logic [31:0]   cfg_word;

    int n_chk = 0;
    int n_err = 0;
    logic pay_bits [0:255];
    int exp_nwords = 0;
    int widx = 0;
    bit mon_en = 1'b0;

    always #2 clk = ~clk;

    assign init_sense = !(init_drive_low || ext_low);

    cfg_sequencer #(.NUM_FRAMES(NF), .GSR_DLY(GSR_D), .DONE_DLY(DONE_D)) dut_i (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .prog_req(prog_req),
        .init_sense(init_sense), .init_drive_low(init_drive_low),
        .din(din), .din_valid(din_valid), .din_last(din_last),
        .clr_addr(clr_addr), .clr_we(clr_we),
        .cfg_word(cfg_word), .cfg_word_vld(cfg_word_vld),
        .gsr(gsr), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int k);
        logic [31:0] w = '0;
        for (int i = 0; i < 32; i++) w = {w[30:0], pay_bits[32*k + i]};
        return w;
    endfunction

    // R4 word monitor
    always @(negedge clk) begin
        if (mon_en && cfg_word_vld === 1'b1) begin
            if (widx < exp_nwords)
                chk(cfg_word === exp_word(widx), "R4", "word value", cfg_word, exp_word(widx));
            else
                chk(1'b0, "R12", "unexpected word", widx, exp_nwords);
            widx++;
        end
    end

    task automatic send_bit(input logic b, input logic l, input bit gaps);
        din = b; din_valid = 1'b1; din_last = l;
        @(negedge clk);
        din_valid = 1'b0; din_last = 1'b0;
        if (gaps && !l) repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic send_len(input logic [31:0] len, input bit last_at_end, input bit gaps);
        for (int i = 31; i >= 0; i--) send_bit(len[i], last_at_end && (i == 0), gaps);
    endtask

    task automatic watch_clear();
        @(negedge clk);
        for (int i = 0; i < NF; i++) begin
            chk(clr_we === 1'b1 && clr_addr == AW'(i) && init_drive_low === 1'b1,
                "R2", "clear step", {clr_we, init_drive_low, 8'(clr_addr)}, {2'b11, 8'(i)});
            @(negedge clk);
        end
        chk(clr_we === 1'b0 && init_drive_low === 1'b0, "R3", "init released after clear",
            {clr_we, init_drive_low}, 2'b00);
        @(negedge clk);
    endtask

    task automatic restart();
        prog_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(done === 1'b0 && gsr === 1'b1 && init_drive_low === 1'b1 && clr_we === 1'b0,
            "R11", "held by program request", {done, gsr, init_drive_low, clr_we}, 4'b0110);
        prog_req = 1'b0;
        watch_clear();
    endtask

    task automatic run_config(input int nbits, input bit gaps);
        int g_n = -1;
        int d_n = -1;
        for (int i = 0; i < nbits; i++) pay_bits[i] = 1'($urandom_range(0, 1));
        exp_nwords = nbits / 32;
        widx = 0;
        mon_en = 1'b1;
        send_len(32'(nbits), nbits == 0, gaps);
        chk(gsr === 1'b1 && done === 1'b0, "R5", "gsr held during load", {gsr, done}, 2'b10);
        for (int i = 0; i < nbits; i++) send_bit(pay_bits[i], i == nbits - 1, gaps);
        for (int n = 1; n <= GSR_D + DONE_D + 3; n++) begin
            @(negedge clk);
            if (g_n < 0 && gsr === 1'b0) g_n = n;
            if (d_n < 0 && done === 1'b1) d_n = n;
        end
        chk(g_n == GSR_D + 1, "R5", "gsr release edge", g_n, GSR_D + 1);
        chk(d_n == GSR_D + DONE_D + 1, "R6", "done edge", d_n, GSR_D + DONE_D + 1);
        repeat (3) send_bit(1'b1, 1'b0, 1'b0);
        chk(done === 1'b1 && gsr === 1'b0, "R6", "done holds", {done, gsr}, 2'b10);
        chk(widx == exp_nwords, "R12", "word count", widx, exp_nwords);
        mon_en = 1'b0;
    endtask

    task automatic expect_error(input string req);
        repeat (2) @(negedge clk);
        chk(init_drive_low === 1'b1 && gsr === 1'b1 && done === 1'b0, req, "fault state",
            {init_drive_low, gsr, done}, 3'b110);
        for (int i = 0; i < 70; i++) send_bit(1'(i), i == 69, 1'b0);
        repeat (GSR_D + DONE_D + 2) @(negedge clk);
        chk(init_drive_low === 1'b1 && gsr === 1'b1 && done === 1'b0, "R10", "fault persists",
            {init_drive_low, gsr, done}, 3'b110);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        rst = 1'b1; pwr_good = 1'b0; prog_req = 1'b0; ext_low = 1'b0;
        din = 1'b0; din_valid = 1'b0; din_last = 1'b0;
        repeat (3) @(negedge clk);
        chk(init_drive_low === 1'b1 && gsr === 1'b1 && done === 1'b0 && clr_we === 1'b0,
            "R1", "reset outputs", {init_drive_low, gsr, done, clr_we}, 4'b1100);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(clr_we === 1'b0 && init_drive_low === 1'b1, "R1", "no power good",
            {clr_we, init_drive_low}, 2'b01);
        pwr_good = 1'b1;
        watch_clear();
        run_config(64, 1'b0);

        // random lengths and strobe spacing
        for (int it = 0; it < 6; it++) begin
            restart();
            run_config($urandom_range(0, 160), it[0]);
        end

        // R3: external stall after clearing; bits sent meanwhile are dropped
        prog_req = 1'b1;
        repeat (2) @(negedge clk);
        ext_low = 1'b1;
        prog_req = 1'b0;
        watch_clear();
        for (int i = 0; i < 15; i++) send_bit(1'b1, 1'b0, 1'b0);
        chk(init_drive_low === 1'b0 && done === 1'b0 && clr_we === 1'b0, "R3", "stalled",
            {init_drive_low, done, clr_we}, 3'b000);
        ext_low = 1'b0;
        @(negedge clk);
        run_config(32, 1'b0);

        // R8: stream ends early
        restart();
        mon_en = 1'b0;
        send_len(32'd64, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) send_bit(1'b0, i == 9, 1'b0);
        expect_error("R8");

        // R7: length one above the limit
        restart();
        send_len(32'hFFFF_FFE1, 1'b0, 1'b0);
        expect_error("R7");

        // R7: length exactly at the limit is accepted
        restart();
        send_len(32'hFFFF_FFE0, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) send_bit(1'b1, 1'b0, 1'b0);
        chk(init_drive_low === 1'b0 && gsr === 1'b1 && done === 1'b0, "R7", "limit accepted",
            {init_drive_low, gsr, done}, 3'b010);

        // R9: init pulled low mid-load
        restart();
        send_len(32'd64, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0, 1'b0);
        ext_low = 1'b1;
        @(negedge clk);
        ext_low = 1'b0;
        expect_error("R9");

        // R11: recovery from fault by program request
        restart();
        run_config(96, 1'b1);

        // R1: power loss in operate
        pwr_good = 1'b0;
        repeat (2) @(negedge clk);
        chk(done === 1'b0 && gsr === 1'b1 && init_drive_low === 1'b1, "R1", "power drop",
            {done, gsr, init_drive_low}, 3'b011);
        pwr_good = 1'b1;
        watch_clear();
        run_config(33, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule